// File: doc/BRIEF.md
# Synchronous Rectifier Skew Generator

This block sits behind the pulse-width modulator of a full-bridge controller. It produces the gate commands for the two synchronous rectifiers of the secondary side. Each rectifier command is the inverse of the lower-bridge command on its own side. A single unsigned skew code shifts the rectifier pair and the bridge commands against each other. The shift can go in either direction, and it is measured in clock cycles.

Codes close to mid-scale fall in a dead band and give no shift. Codes below the band hold back the lower PWM pair, and the upper 50% pair is held back by the same number of cycles, so the bridge keeps its own internal timing. Codes above the band hold back the rectifier pair instead. The amount grows with the square of the distance from the band, so steps are fine near the centre and coarse near the ends. A new code takes effect only when the oscillator marks the end of a cycle, so a shift never changes halfway through a pulse.

Top module: `sr_skew_gen`

## Requirements
- R1: With no rectifier shift, `sr_l` equals NOT `pwm_l` and `sr_r` equals NOT `pwm_r` in the same cycle. With no bridge shift, `pwm_l_o`, `pwm_r_o`, `up_l_o` and `up_r_o` follow their inputs in the same cycle.
- R2: While both lower PWM inputs are low, both rectifier outputs are high. While only one lower PWM input is high, only the rectifier output on that side goes low, and the other stays high.
- R3: With MID = 2^(CODE_W-1), a code c with |c - MID| <= DEAD gives a zero shift on both paths.
- R4: A code c < MID - DEAD delays the bridge outputs and leaves the rectifier outputs unshifted. A code c > MID + DEAD delays the rectifier outputs and leaves the bridge outputs unshifted. The two paths are never shifted at the same time.
- R5: Outside the band, the index m = |c - MID| - DEAD - 1 is clamped to STEPS - 1, where STEPS = MID - DEAD. The shift is MIN_CYC + floor((MAX_CYC - MIN_CYC) * m^2 / (STEPS - 1)^2) cycles.
- R6: The upper pair `up_l_o`/`up_r_o` is delayed by exactly the same number of cycles as the lower PWM pair.
- R7: The bridge-side shift is clamped to at most PWM_MAX cycles. This bound keeps the shift inside the dead time.
- R8: The skew code is sampled only at a clock edge where `osc_tick` is high. The new shift applies from the next cycle. A code change without a tick has no effect.
- R9: Reset sets both shifts to zero and clears every delay stage. With all inputs low, the bridge outputs are then low and the rectifier outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Oscillator cycle boundary strobe; loads the skew code |
| skew_code | input | CODE_W | Unsigned skew control, mid-scale = zero |
| pwm_l | input | 1 | Lower-left PWM command |
| pwm_r | input | 1 | Lower-right PWM command |
| up_l | input | 1 | Upper-left 50% command |
| up_r | input | 1 | Upper-right 50% command |
| pwm_l_o | output | 1 | Shifted lower-left command |
| pwm_r_o | output | 1 | Shifted lower-right command |
| up_l_o | output | 1 | Shifted upper-left command |
| up_r_o | output | 1 | Shifted upper-right command |
| sr_l | output | 1 | Left rectifier command |
| sr_r | output | 1 | Right rectifier command |

## Verification
The bench builds the block with its defaults: a 6-bit code, a dead band of 2, a shift curve from 2 to 15 cycles and a bridge limit of 12 cycles. These values keep the whole curve to 30 entries, so the bench can reach both band edges, the first step on each side and the two extremes of the code. Because the curve peaks above the bridge limit, the clamp becomes active at code 0, while the rectifier side still reaches 14 cycles at code 63.

// File: rtl/sr_skew_pkg.sv
// Shared helpers for the rectifier skew generator.
// Assumes: called only at elaboration to fill constant curves.
package sr_skew_pkg;

    // Quadratic skew curve: fine near the dead band, coarse at the ends.
    function automatic int skew_cycles(input int m, input int steps,
                                       input int lo, input int hi);
        int den;
        den = (steps - 1) * (steps - 1);
        if (den <= 0) return lo;
        return lo + ((hi - lo) * m * m) / den;
    endfunction

endpackage

// File: rtl/sr_skew_map.sv
// Maps the unsigned skew code to a shift amount for each path.
// Assumes: MID = 2^(CODE_W-1), DEAD < MID - 1, PWM_MAX <= MAX_CYC.
// Purely combinational; the curve is built as constants at elaboration.
module sr_skew_map #(
    parameter int CODE_W  = 6,
    parameter int DEAD    = 2,
    parameter int MIN_CYC = 2,
    parameter int MAX_CYC = 15,
    parameter int PWM_MAX = 12,
    parameter int CNT_W   = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  pwm_amt,
    output logic [CNT_W-1:0]  sr_amt
);
    import sr_skew_pkg::*;

    localparam int MID   = 1 << (CODE_W - 1);
    localparam int STEPS = MID - DEAD;
    localparam logic [CODE_W:0] HI_EDGE = (CODE_W + 1)'(MID + DEAD);
    localparam logic [CODE_W:0] LO_EDGE = (CODE_W + 1)'(MID - DEAD);
    localparam logic [CODE_W:0] LAST    = (CODE_W + 1)'(STEPS - 1);
    localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(PWM_MAX);

    logic [CNT_W-1:0] curve [STEPS];
    logic [CODE_W:0]  code_x;
    logic [CODE_W:0]  mag;
    logic             above;
    logic             below;
    logic [CNT_W-1:0] cyc;

    // One constant curve entry per magnitude step.
    for (genvar g = 0; g < STEPS; g++) begin : g_curve
        assign curve[g] = CNT_W'(skew_cycles(g, STEPS, MIN_CYC, MAX_CYC));
    end

    // Classify the code against the dead band and compute the step index.
    always_comb begin
        code_x = {1'b0, code};
        above  = code_x > HI_EDGE;
        below  = code_x < LO_EDGE;
        if (above)      mag = code_x - HI_EDGE - 1'b1;
        else if (below) mag = LO_EDGE - code_x - 1'b1;
        else            mag = '0;
        if (mag > LAST) mag = LAST;
    end

    // Look up the amount and steer it to one path, clamping the bridge side.
    always_comb begin
        cyc = '0;
        for (int i = 0; i < STEPS; i++) begin
            if (mag == (CODE_W + 1)'(i)) cyc = curve[i];
        end
        pwm_amt = '0;
        sr_amt  = '0;
        if (below)      pwm_amt = (cyc > LIMIT) ? LIMIT : cyc;
        else if (above) sr_amt  = cyc;
    end

endmodule

// File: rtl/sr_tap_delay.sv
// Multi-bit shift line with a selectable tap; tap 0 passes input through.
// Assumes: tap never exceeds DEPTH; reset clears every stage to zero.
module sr_tap_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 15,
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     din,
    input  logic [TAP_W-1:0] tap,
    output logic [W-1:0]     dout
);
    logic [W-1:0] line [DEPTH];

    // Shift the input through the stages once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    // Select the stage matching the requested delay.
    always_comb begin
        dout = din;
        for (int i = 0; i < DEPTH; i++) begin
            if (tap == TAP_W'(i + 1)) dout = line[i];
        end
    end

endmodule

// File: rtl/sr_skew_gen.sv
// Synchronous rectifier skew generator: inverts each lower PWM command into
// a rectifier command, and delays either the bridge group (lower plus upper)
// or the rectifier group by a code-selected number of cycles.
// Assumes: osc_tick pulses once per oscillator cycle at a boundary.
module sr_skew_gen #(
    parameter int CODE_W  = 6,
    parameter int DEAD    = 2,
    parameter int MIN_CYC = 2,
    parameter int MAX_CYC = 15,
    parameter int PWM_MAX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [CODE_W-1:0] skew_code,
    input  logic              pwm_l,
    input  logic              pwm_r,
    input  logic              up_l,
    input  logic              up_r,
    output logic              pwm_l_o,
    output logic              pwm_r_o,
    output logic              up_l_o,
    output logic              up_r_o,
    output logic              sr_l,
    output logic              sr_r
);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] pwm_next, sr_next;
    logic [CNT_W-1:0] pwm_dly, sr_dly;
    logic [3:0]       bridge_d;
    logic [1:0]       rect_d;

    sr_skew_map #(
        .CODE_W(CODE_W), .DEAD(DEAD), .MIN_CYC(MIN_CYC),
        .MAX_CYC(MAX_CYC), .PWM_MAX(PWM_MAX), .CNT_W(CNT_W)
    ) u_map (
        .code(skew_code), .pwm_amt(pwm_next), .sr_amt(sr_next)
    );

    // Latch the shift amounts only at an oscillator boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_dly <= '0;
            sr_dly  <= '0;
        end else if (osc_tick) begin
            pwm_dly <= pwm_next;
            sr_dly  <= sr_next;
        end
    end

    sr_tap_delay #(.W(4), .DEPTH(MAX_CYC), .TAP_W(CNT_W)) u_bridge (
        .clk(clk), .rst_n(rst_n), .din({up_l, up_r, pwm_l, pwm_r}),
        .tap(pwm_dly), .dout(bridge_d)
    );

    sr_tap_delay #(.W(2), .DEPTH(MAX_CYC), .TAP_W(CNT_W)) u_rect (
        .clk(clk), .rst_n(rst_n), .din({pwm_l, pwm_r}),
        .tap(sr_dly), .dout(rect_d)
    );

    // Drive the bridge outputs and the inverted rectifier outputs.
    always_comb begin
        {up_l_o, up_r_o, pwm_l_o, pwm_r_o} = bridge_d;
        sr_l = ~rect_d[1];
        sr_r = ~rect_d[0];
    end

endmodule

// File: rtl/sr_skew_chk.sv
// Property checker for sr_skew_gen, attached by bind below.
// Assumes: observes the latched shift amounts and the block ports.
module sr_skew_chk #(
    parameter int MIN_CYC = 2,
    parameter int MAX_CYC = 15,
    parameter int PWM_MAX = 12,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_tick,
    input logic             pwm_l,
    input logic             pwm_r,
    input logic             up_l,
    input logic             pwm_l_o,
    input logic             up_l_o,
    input logic             sr_l,
    input logic             sr_r,
    input logic [CNT_W-1:0] pwm_dly,
    input logic [CNT_W-1:0] sr_dly
);
    // R1: unshifted rectifiers are the inverted inputs.
    p_sr_comp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_dly == '0) |-> (sr_l == !pwm_l) && (sr_r == !pwm_r));

    // R4: never shift both paths.
    p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((pwm_dly != '0) && (sr_dly != '0)));

    // R5: rectifier shift lies on the curve range.
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_dly == '0) || ((sr_dly >= CNT_W'(MIN_CYC)) && (sr_dly <= CNT_W'(MAX_CYC))));

    // R6: unshifted bridge passes the upper and lower commands together.
    p_up_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_dly == '0) |-> (up_l_o == up_l) && (pwm_l_o == pwm_l));

    // R7: bridge shift never exceeds its limit.
    p_pwm_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_dly <= CNT_W'(PWM_MAX));

    // R8: no tick, no change in the shift.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(pwm_dly) && $stable(sr_dly));

endmodule

bind sr_skew_gen sr_skew_chk #(
    .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .PWM_MAX(PWM_MAX), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pwm_l(pwm_l),
    .pwm_r(pwm_r), .up_l(up_l), .pwm_l_o(pwm_l_o), .up_l_o(up_l_o),
    .sr_l(sr_l), .sr_r(sr_r), .pwm_dly(pwm_dly), .sr_dly(sr_dly)
);

// File: tb/sim_sr_skew_gen.sv
// Bench for sr_skew_gen: vector table of code/expected shifts, then directed cases.
module sim_sr_skew_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [5:0] skew_code = 6'd32;
    logic       pwm_l = 1'b0, pwm_r = 1'b0, up_l = 1'b0, up_r = 1'b0;
    logic       pwm_l_o, pwm_r_o, up_l_o, up_r_o, sr_l, sr_r;

    int checks = 0;
    int errors = 0;
    int n_pwm, n_up, n_sr;
    bit other_ok;
    bit done = 0;

    always #10 clk = ~clk;

    sr_skew_gen u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .skew_code(skew_code),
        .pwm_l(pwm_l), .pwm_r(pwm_r), .up_l(up_l), .up_r(up_r),
        .pwm_l_o(pwm_l_o), .pwm_r_o(pwm_r_o), .up_l_o(up_l_o),
        .up_r_o(up_r_o), .sr_l(sr_l), .sr_r(sr_r)
    );

    // {code, expected bridge shift, expected rectifier shift}; formula of R5, clamp of R7
    localparam int VEC [11][3] = '{
        '{32, 0, 0}, '{34, 0, 0}, '{30, 0, 0}, '{35, 0, 2}, '{29, 2, 0},
        '{45, 0, 3}, '{50, 0, 5}, '{63, 0, 14}, '{20, 3, 0}, '{10, 7, 0},
        '{0, 12, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_code(input int c);
        @(negedge clk);
        skew_code = 6'(c);
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        pwm_l = 0; pwm_r = 0; up_l = 0; up_r = 0;
        repeat (20) @(negedge clk);
    endtask

    // Raise the left lower and upper commands and count cycles to each response.
    task automatic measure_left();
        n_pwm = 99; n_up = 99; n_sr = 99; other_ok = 1;
        @(negedge clk);
        pwm_l = 1; up_l = 1;
        #1;
        for (int i = 0; i < 24; i++) begin
            if (i > 0) begin @(posedge clk); #1; end
            if (pwm_l_o && n_pwm == 99) n_pwm = i;
            if (up_l_o && n_up == 99) n_up = i;
            if (!sr_l && n_sr == 99) n_sr = i;
            if (!sr_r) other_ok = 0;
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state with idle inputs
        check(!pwm_l_o && !up_l_o && !pwm_r_o && !up_r_o, "R9 bridge low in reset", pwm_l_o, 0);
        check(sr_l && sr_r, "R9 rectifiers high in reset", {sr_l, sr_r}, 3);
        rst_n = 1'b1;
        settle();
        // R2: freewheel keeps both rectifiers high
        check(sr_l && sr_r, "R2 freewheel both high", {sr_l, sr_r}, 3);

        // Table walk: R3, R4, R5, R6, R7 per vector
        for (int v = 0; v < 11; v++) begin
            load_code(VEC[v][0]);
            settle();
            measure_left();
            check(n_pwm == VEC[v][1], $sformatf("R4/R5/R7 bridge shift code %0d", VEC[v][0]), n_pwm, VEC[v][1]);
            check(n_up == VEC[v][1], $sformatf("R6 upper shift code %0d", VEC[v][0]), n_up, VEC[v][1]);
            check(n_sr == VEC[v][2], $sformatf("R3/R5 rectifier shift code %0d", VEC[v][0]), n_sr, VEC[v][2]);
            check(other_ok, "R2 opposite rectifier stays high", other_ok, 1);
            settle();
        end

        // R1, R2: right side, no shift, same-cycle inversion
        load_code(32);
        settle();
        @(negedge clk);
        pwm_r = 1; up_r = 1;
        #1;
        check(!sr_r && sr_l, "R1 right rectifier inverts at once", {sr_l, sr_r}, 2);
        check(pwm_r_o && up_r_o, "R1 right bridge passes through", {pwm_r_o, up_r_o}, 3);
        settle();

        // R8: code change without a tick is ignored
        load_code(35);
        settle();
        @(negedge clk);
        skew_code = 6'd0;
        settle();
        measure_left();
        check(n_sr == 2, "R8 rectifier shift held without tick", n_sr, 2);
        check(n_pwm == 0, "R8 bridge shift held without tick", n_pwm, 0);
        settle();

        // R9: reset clears a latched shift
        load_code(0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        measure_left();
        check(n_pwm == 0, "R9 shift cleared by reset", n_pwm, 0);
        check(n_sr == 0, "R9 rectifier shift cleared by reset", n_sr, 0);
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule